// File: doc/BRIEF.md
# Multiplexed LCD Row Scan Controller

This block sequences the rows of a multiplexed dot-matrix LCD with 40 driver outputs. An oscillator clock is divided into a cascade clock for external column drivers. Every fixed number of divided-clock periods the controller steps to the next display row. It drives a row-select pulse onto the outputs assigned to rows, and it places one row of display RAM data, shaded by the display status, onto the outputs assigned to columns. A one-period SYNC pulse marks the start of each frame so that cascaded column drivers stay aligned.

Configuration is held in four registers, which one write strobe loads together: the multiplex rate, row-only or mixed mode, the start bank and the display status. The first eight outputs are always rows and the last eight are always columns. The three middle groups of eight switch role with the mode and the rate. At 1:8 and 1:16 the row pulse is repeated in every group that spans the rate. The start bank rotates which of the four RAM banks of eight rows is shown at the top of the display.

The fetch state machine has three states. ST_FETCH issues one RAM read for the row that will be shown next and then moves to ST_CAPTURE. ST_CAPTURE stores the returned word and then moves to ST_HOLD. ST_HOLD waits for the end of the current row and then returns to ST_FETCH. Reset enters ST_FETCH, so row 0 is fetched while the first, undisplayed row period runs.

Top module: `lcd_scan_ctrl`

## Requirements
- R1: After reset the rate is 1:32, the mode is row-only and the display is blank. Until the first row boundary, row_sel and col_data are all zero and sync is low.
- R2: col_role bit k is 1 when output k is a column. Outputs 0–7 are always rows (bits 0) and outputs 32–39 are always columns (bits 1).
- R3: In row-only mode outputs 8–31 are rows. In mixed mode, group g (outputs 8g..8g+7, g = 1..3) is a row group when g < code+1 and a column group otherwise. The rate codes are 00 = 1:8, 01 = 1:16, 10 = 1:24 and 11 = 1:32.
- R4: The rows are shown in the order 0, 1, …, N−1 and then 0 again, with N = 8·(code+1). Each row lasts 4 cascade-clock periods. The row pulse for row n is on output n.
- R5: At 1:16 the pulse for row n also appears on output n+16, and at 1:8 it also appears on n+8, n+16 and n+24, but only on outputs that are rows. At 1:24 outputs 24–31 get no pulse.
- R6: cas_clk has a period of 8 oscillator cycles at 1:24 and 6 cycles at the other rates.
- R7: sync rises on the same edge that selects row 0 and stays high for exactly one cas_clk period. The frame period is N·4·(cas_clk period).
- R8: One RAM read is made per row, for the upcoming row. The bank is (row/8 + start bank) mod 4 and the row within the bank is row mod 8. The data returns one cycle after ram_rd_en.
- R9: A column output k carries bit k of the fetched word. Row outputs carry 0, so RAM bits 0–7 are never shown.
- R10: The display status sets the column outputs: 00 = blank (all 0), 01 = all on (all 1), 10 = normal (word bit), 11 = inverse (inverted bit).
- R11: cfg_wr loads the rate, mode, start bank and status together at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Load strobe for all configuration fields |
| cfg_rate | input | 2 | Multiplex rate code |
| cfg_mixed | input | 1 | 1 = mixed mode, 0 = row-only |
| cfg_bank | input | 2 | Start bank shown at the top row |
| cfg_disp | input | 2 | Display status code |
| ram_rd_en | output | 1 | RAM read strobe |
| ram_rd_bank | output | 2 | RAM bank address |
| ram_rd_row | output | 3 | Row within the bank |
| ram_rd_data | input | 40 | RAM row word, one cycle after the strobe |
| row_sel | output | 40 | Row select pulse per output |
| col_role | output | 40 | 1 = output acts as a column |
| col_data | output | 40 | Shaded column data per output |
| cas_clk | output | 1 | Divided clock for cascaded column drivers |
| sync | output | 1 | Frame start pulse |

## Verification
The bench runs every rate in both modes and checks each row of a full frame. This catches a design that replicates the pulse at 1:24, which would put stray pulses on outputs 24–31. It also catches a design that replicates the pulse onto outputs that mixed mode has made columns. A start bank of 2 at 1:24 forces the bank index to wrap past 3; a design with a wrong bank adder would show the wrong rows from the third group on. The bench measures the cascade period, the SYNC width and the frame length at 1:24 against the other rates, which exposes a divider that ignores the rate. The blank, all-on and inverse codes are each checked at the column outputs, which exposes a swapped status decode.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
    typedef enum logic [1:0] {
        RATE_8  = 2'd0,
        RATE_16 = 2'd1,
        RATE_24 = 2'd2,
        RATE_32 = 2'd3
    } rate_t;

    typedef enum logic [1:0] {
        DISP_BLANK   = 2'd0,
        DISP_ON      = 2'd1,
        DISP_NORMAL  = 2'd2,
        DISP_INVERSE = 2'd3
    } disp_t;

    typedef enum logic [1:0] {
        ST_FETCH   = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_HOLD    = 2'd2
    } scan_st_t;
endpackage

// File: rtl/lcd_clk_div.sv
module lcd_clk_div
    import lcd_scan_pkg::*;
#(
    parameter int DIV_STD = 6,
    parameter int DIV_ALT = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  rate_t rate,
    output logic  tick,
    output logic  cas_clk
);
    localparam int DIV_MAX = (DIV_ALT > DIV_STD) ? DIV_ALT : DIV_STD;
    localparam int CW      = $clog2(DIV_MAX);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;
    logic [CW-1:0] lim_m1;
    logic [CW:0]   half;

    always_comb begin
        if (rate == RATE_24) begin
            lim_m1 = CW'(DIV_ALT - 1);
            half   = (CW+1)'(DIV_ALT / 2);
        end else begin
            lim_m1 = CW'(DIV_STD - 1);
            half   = (CW+1)'(DIV_STD / 2);
        end
        tick    = (cnt_q >= lim_m1);
        cnt_nxt = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            cas_clk <= 1'b1;
        end else begin
            cnt_q   <= cnt_nxt;
            cas_clk <= ({1'b0, cnt_nxt} < half);
        end
    end
endmodule

// File: rtl/lcd_role_map.sv
module lcd_role_map
    import lcd_scan_pkg::*;
#(
    parameter int GRP_W   = 8,
    parameter int NUM_GRP = 5,
    parameter int ROW_W   = 5
) (
    input  rate_t                    rate,
    input  logic                     mixed,
    input  logic [ROW_W-1:0]         cur_row,
    input  logic                     row_valid,
    output logic [GRP_W*NUM_GRP-1:0] col_role,
    output logic [GRP_W*NUM_GRP-1:0] row_sel
);
    localparam int NUM_OUT = GRP_W * NUM_GRP;

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
        localparam int GRP = k / GRP_W;
        localparam logic [ROW_W-1:0] M8  = ROW_W'(k % GRP_W);
        localparam logic [ROW_W-1:0] M16 = ROW_W'(k % (2 * GRP_W));
        localparam logic [ROW_W-1:0] M32 = ROW_W'(k % (4 * GRP_W));
        localparam logic [ROW_W-1:0] M24 = ROW_W'(k % (4 * GRP_W));
        logic is_row;
        logic hit;

        always_comb begin
            if (GRP == 0)
                is_row = 1'b1;
            else if (GRP >= NUM_GRP - 1)
                is_row = 1'b0;
            else
                is_row = !mixed || (GRP < int'(rate) + 1);

            unique case (rate)
                RATE_8:  hit = (cur_row == M8);
                RATE_16: hit = (cur_row == M16);
                RATE_24: hit = (k < 3 * GRP_W) && (cur_row == M24);
                RATE_32: hit = (cur_row == M32);
                default: hit = 1'b0;
            endcase
        end

        assign col_role[k] = !is_row;
        assign row_sel[k]  = is_row && hit && row_valid;
    end
endmodule

// File: rtl/lcd_scan_fsm.sv
module lcd_scan_fsm
    import lcd_scan_pkg::*;
#(
    parameter int GRP_W     = 8,
    parameter int NUM_OUT   = 40,
    parameter int ROW_W     = 5,
    parameter int ROW_TICKS = 4,
    parameter int BANK_W    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  rate_t              rate,
    input  logic [BANK_W-1:0]  start_bank,
    input  disp_t              disp,
    input  logic [NUM_OUT-1:0] ram_rd_data,
    output logic               ram_rd_en,
    output logic [BANK_W-1:0]  ram_rd_bank,
    output logic [$clog2(GRP_W)-1:0] ram_rd_row,
    output logic [ROW_W-1:0]   cur_row,
    output logic               row_valid,
    output logic [NUM_OUT-1:0] col_shade,
    output logic               sync
);
    localparam int IN_W = $clog2(GRP_W);
    localparam int TCW  = $clog2(ROW_TICKS) + 1;

    scan_st_t           state_q, state_d;
    logic [TCW-1:0]     tick_cnt;
    logic [ROW_W-1:0]   row_ptr;
    logic [ROW_W-1:0]   last_row;
    logic [NUM_OUT-1:0] word_buf;
    logic               row_end;

    assign row_end  = tick && (tick_cnt == TCW'(ROW_TICKS - 1));
    assign last_row = ROW_W'((int'(rate) + 1) * GRP_W - 1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH:   state_d = ST_CAPTURE;
            ST_CAPTURE: state_d = ST_HOLD;
            ST_HOLD:    if (row_end) state_d = ST_FETCH;
            default:    state_d = ST_FETCH;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        ram_rd_en   = (state_q == ST_FETCH);
        ram_rd_bank = row_ptr[ROW_W-1:IN_W] + start_bank;
        ram_rd_row  = row_ptr[IN_W-1:0];
    end

    // row sequencing and data path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt  <= '0;
            row_ptr   <= '0;
            cur_row   <= '0;
            row_valid <= 1'b0;
            sync      <= 1'b0;
            word_buf  <= '0;
            col_shade <= '0;
        end else begin
            if (state_q == ST_CAPTURE)
                word_buf <= ram_rd_data;
            if (tick)
                tick_cnt <= row_end ? '0 : tick_cnt + 1'b1;
            if (row_end) begin
                cur_row   <= row_ptr;
                row_ptr   <= (row_ptr >= last_row) ? '0 : row_ptr + 1'b1;
                row_valid <= 1'b1;
                sync      <= (row_ptr == '0);
                unique case (disp)
                    DISP_BLANK:   col_shade <= '0;
                    DISP_ON:      col_shade <= '1;
                    DISP_NORMAL:  col_shade <= word_buf;
                    DISP_INVERSE: col_shade <= ~word_buf;
                    default:      col_shade <= '0;
                endcase
            end else if (tick) begin
                sync <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
    import lcd_scan_pkg::*;
#(
    parameter int GRP_W     = 8,
    parameter int NUM_GRP   = 5,
    parameter int NUM_BANK  = 4,
    parameter int ROW_TICKS = 4,
    parameter int DIV_STD   = 6,
    parameter int DIV_ALT   = 8,
    localparam int NUM_OUT  = GRP_W * NUM_GRP,
    localparam int ROW_W    = $clog2(NUM_BANK * GRP_W),
    localparam int BANK_W   = $clog2(NUM_BANK),
    localparam int IN_W     = $clog2(GRP_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [1:0]         cfg_rate,
    input  logic               cfg_mixed,
    input  logic [BANK_W-1:0]  cfg_bank,
    input  logic [1:0]         cfg_disp,
    output logic               ram_rd_en,
    output logic [BANK_W-1:0]  ram_rd_bank,
    output logic [IN_W-1:0]    ram_rd_row,
    input  logic [NUM_OUT-1:0] ram_rd_data,
    output logic [NUM_OUT-1:0] row_sel,
    output logic [NUM_OUT-1:0] col_role,
    output logic [NUM_OUT-1:0] col_data,
    output logic               cas_clk,
    output logic               sync
);
    rate_t              rate_q;
    logic               mixed_q;
    logic [BANK_W-1:0]  bank_q;
    disp_t              disp_q;
    logic               tick;
    logic [ROW_W-1:0]   cur_row;
    logic               row_valid;
    logic [NUM_OUT-1:0] col_shade;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate_q  <= RATE_32;
            mixed_q <= 1'b0;
            bank_q  <= '0;
            disp_q  <= DISP_BLANK;
        end else if (cfg_wr) begin
            rate_q  <= rate_t'(cfg_rate);
            mixed_q <= cfg_mixed;
            bank_q  <= cfg_bank;
            disp_q  <= disp_t'(cfg_disp);
        end
    end

    lcd_clk_div #(.DIV_STD(DIV_STD), .DIV_ALT(DIV_ALT)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .rate    (rate_q),
        .tick    (tick),
        .cas_clk (cas_clk)
    );

    lcd_scan_fsm #(
        .GRP_W(GRP_W), .NUM_OUT(NUM_OUT), .ROW_W(ROW_W),
        .ROW_TICKS(ROW_TICKS), .BANK_W(BANK_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .rate        (rate_q),
        .start_bank  (bank_q),
        .disp        (disp_q),
        .ram_rd_data (ram_rd_data),
        .ram_rd_en   (ram_rd_en),
        .ram_rd_bank (ram_rd_bank),
        .ram_rd_row  (ram_rd_row),
        .cur_row     (cur_row),
        .row_valid   (row_valid),
        .col_shade   (col_shade),
        .sync        (sync)
    );

    lcd_role_map #(.GRP_W(GRP_W), .NUM_GRP(NUM_GRP), .ROW_W(ROW_W)) u_map (
        .rate      (rate_q),
        .mixed     (mixed_q),
        .cur_row   (cur_row),
        .row_valid (row_valid),
        .col_role  (col_role),
        .row_sel   (row_sel)
    );

    // a column output drops its data as soon as its role turns to row
    assign col_data = col_shade & col_role;
endmodule

// File: rtl/lcd_scan_chk.sv
module lcd_scan_chk #(
    parameter int GRP_W   = 8,
    parameter int NUM_OUT = 40
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ram_rd_en,
    input logic [NUM_OUT-1:0] row_sel,
    input logic [NUM_OUT-1:0] col_role,
    input logic               cas_clk,
    input logic               sync
);
    assert_fixed_roles_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (col_role[GRP_W-1:0] == '0) && (&col_role[NUM_OUT-1:NUM_OUT-GRP_W]));

    assert_single_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_sel[GRP_W-1:0]));

    assert_no_pulse_on_column_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (row_sel & col_role) == '0);

    assert_cas_high_min_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_clk) |=> cas_clk);

    assert_sync_on_row0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sync |-> row_sel[0]);

    assert_one_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd_en |=> !ram_rd_en);
endmodule

bind lcd_scan_ctrl lcd_scan_chk #(.GRP_W(GRP_W), .NUM_OUT(NUM_OUT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ram_rd_en (ram_rd_en),
    .row_sel   (row_sel),
    .col_role  (col_role),
    .cas_clk   (cas_clk),
    .sync      (sync)
);

// File: tb/test_lcd_scan_ctrl.sv
`timescale 1ns/1ps
module test_lcd_scan_ctrl;
    localparam int NO = 40;
    localparam int RT = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [1:0]    cfg_rate = 2'd3;
    logic          cfg_mixed = 1'b0;
    logic [1:0]    cfg_bank = 2'd0;
    logic [1:0]    cfg_disp = 2'd0;
    logic          ram_rd_en;
    logic [1:0]    ram_rd_bank;
    logic [2:0]    ram_rd_row;
    logic [NO-1:0] ram_rd_data = '0;
    logic [NO-1:0] row_sel, col_role, col_data;
    logic          cas_clk, sync;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    lcd_scan_ctrl i_lcd_scan_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rate(cfg_rate),
        .cfg_mixed(cfg_mixed), .cfg_bank(cfg_bank), .cfg_disp(cfg_disp),
        .ram_rd_en(ram_rd_en), .ram_rd_bank(ram_rd_bank), .ram_rd_row(ram_rd_row),
        .ram_rd_data(ram_rd_data), .row_sel(row_sel), .col_role(col_role),
        .col_data(col_data), .cas_clk(cas_clk), .sync(sync)
    );

    function automatic logic [NO-1:0] pattern(int b, int r);
        logic [4:0] t;
        t = 5'((b << 3) | r);
        return {8{t}} ^ 40'hC35A960FE1;
    endfunction

    // RAM model: one-cycle read latency
    always @(posedge clk)
        if (ram_rd_en) ram_rd_data <= pattern(int'(ram_rd_bank), int'(ram_rd_row));

    function automatic int div_of(int rate);
        return (rate == 2) ? 8 : 6;
    endfunction

    function automatic logic is_row(int k, int rate, logic mixed);
        int g;
        g = k / 8;
        if (g == 0) return 1'b1;
        if (g >= 4) return 1'b0;
        return !mixed || (g < rate + 1);
    endfunction

    function automatic logic [NO-1:0] exp_role(int rate, logic mixed);
        logic [NO-1:0] v;
        for (int k = 0; k < NO; k++) v[k] = !is_row(k, rate, mixed);
        return v;
    endfunction

    function automatic logic [NO-1:0] exp_sel(int rate, logic mixed, int row);
        logic [NO-1:0] v;
        for (int k = 0; k < NO; k++) begin
            if (rate == 2) v[k] = is_row(k, rate, mixed) && (k == row);
            else           v[k] = is_row(k, rate, mixed) && ((k % (8 * (rate + 1))) == row);
        end
        return v;
    endfunction

    function automatic logic [NO-1:0] exp_col(int rate, logic mixed, int bank, int disp, int row);
        logic [NO-1:0] w, v;
        w = pattern(((row / 8) + bank) % 4, row % 8);
        for (int k = 0; k < NO; k++) begin
            if (is_row(k, rate, mixed)) v[k] = 1'b0;
            else case (disp)
                0: v[k] = 1'b0;
                1: v[k] = 1'b1;
                2: v[k] = w[k];
                default: v[k] = ~w[k];
            endcase
        end
        return v;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [NO-1:0] act, input logic [NO-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    task automatic write_cfg(input int rate, input logic mixed, input int bank, input int disp);
        @(negedge clk);
        cfg_rate = 2'(rate); cfg_mixed = mixed; cfg_bank = 2'(bank); cfg_disp = 2'(disp);
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic wait_sync_rise();
        do @(negedge clk); while (sync);
        do @(negedge clk); while (!sync);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(row_sel == '0, "R1 row_sel after reset", row_sel, '0);
        chk(col_data == '0, "R1 col_data after reset", col_data, '0);
        chk(sync == 1'b0, "R1 sync after reset", NO'(sync), '0);
        chk(col_role == exp_role(3, 1'b0), "R1 R2 roles after reset", col_role, exp_role(3, 1'b0));
        wait_sync_rise();
        for (int i = 0; i < 4; i++) begin
            if (i == 0) @(negedge clk); else repeat (RT * 6) @(negedge clk);
            chk(row_sel == exp_sel(3, 1'b0, i), "R1 default 1:32 scan", row_sel, exp_sel(3, 1'b0, i));
            chk(col_data == '0, "R1 default blank", col_data, '0);
        end
    endtask

    task automatic t_frame(input int rate, input logic mixed, input int bank, input int disp);
        int per, nrow;
        per  = RT * div_of(rate);
        nrow = 8 * (rate + 1);
        write_cfg(rate, mixed, bank, disp);  // R11: fields take effect together
        wait_sync_rise();
        wait_sync_rise();
        for (int i = 0; i < nrow; i++) begin
            if (i == 0) @(negedge clk); else repeat (per) @(negedge clk);
            chk(col_role == exp_role(rate, mixed), "R2 R3 R11 col_role", col_role, exp_role(rate, mixed));
            chk(row_sel == exp_sel(rate, mixed, i), "R4 R5 row_sel", row_sel, exp_sel(rate, mixed, i));
            chk(col_data == exp_col(rate, mixed, bank, disp, i), "R8 R9 R10 col_data",
                col_data, exp_col(rate, mixed, bank, disp, i));
            chk(sync == (i == 0), "R7 sync in row", NO'(sync), NO'(i == 0));
        end
    endtask

    task automatic t_timing(input int rate);
        int n, hi;
        write_cfg(rate, 1'b0, 0, 2);
        wait_sync_rise();
        wait_sync_rise();
        n = 0;
        do begin @(negedge clk); n++; end while (sync);
        hi = n;
        do begin @(negedge clk); n++; end while (!sync);
        chk(hi == div_of(rate), "R7 sync width", NO'(hi), NO'(div_of(rate)));
        chk(n == 8 * (rate + 1) * RT * div_of(rate), "R7 frame length", NO'(n),
            NO'(8 * (rate + 1) * RT * div_of(rate)));
        do @(negedge clk); while (cas_clk);
        do @(negedge clk); while (!cas_clk);
        n = 0;
        do begin @(negedge clk); n++; end while (cas_clk);
        do begin @(negedge clk); n++; end while (!cas_clk);
        chk(n == div_of(rate), "R6 cas_clk period", NO'(n), NO'(div_of(rate)));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_frame(3, 1'b0, 0, 2);
        t_frame(1, 1'b0, 1, 3);
        t_frame(0, 1'b0, 3, 1);
        t_frame(2, 1'b1, 2, 2);
        t_frame(1, 1'b1, 0, 0);
        t_frame(0, 1'b1, 1, 2);
        t_frame(2, 1'b0, 3, 3);
        t_frame(3, 1'b1, 1, 2);
        t_timing(2);
        t_timing(3);
        t_timing(0);
        summary();
        $finish;
    end
endmodule